// File: doc/BRIEF.md
# Physical Address Window Remapper

This block sits after an address translation unit and adjusts the physical addresses that the unit produces. In large-memory mode it moves every outgoing translation into the 34-bit window above 4 GiB by forcing address bit 32 high. It then checks the result against a programmable valid window on bits 32:30. A translation that lands in the low 1 GiB I/O hole, or outside the window, is replaced by a 128-byte aligned protect address, and a fault cause is reported with it.

A separate, purely combinational reverse path converts device-view addresses back to the processor view. In large-memory mode, addresses at or above 0x1_4000_0000 lose bit 32. Lower addresses are returned unchanged. With the mode off, both paths are identity and the window check is skipped.

Top module: `pa_window_remap`

## Requirements
- R1: With mode_en high, a non-faulting forward beat leaves on out_addr with bit 32 set and every other bit equal to the input. out_valid rises exactly one clock after in_valid.
- R2: The reverse path is combinational. With mode_en high, rev_in at or above 0x1_4000_0000 appears on rev_out with bit 32 cleared, and smaller values appear unchanged.
- R3: A forward input whose bits 33:30 are all zero targets the I/O hole. It is flagged with out_cause = 1 and out_addr = protect address, whatever the mode.
- R4: rng_cfg[7:0] is the window start and rng_cfg[15:8] is the window end. Both are compared, inclusively, against bits 32:30 of the mode-adjusted address. Outside the window, out_cause = 2 and out_addr = protect address. Exactly at either bound, the beat passes. I/O-hole detection takes priority over the window check.
- R5: The protect address driven on a fault is prot_addr with bits 6:0 forced to zero.
- R6: With mode_en low, the forward path returns the input unchanged, and no window fault is raised. The reverse path also returns its input unchanged.
- R7: out_cause is non-zero only in a cycle where out_valid is high, so a fault is a one-cycle pulse per beat. After an idle cycle, out_valid and out_cause are zero.
- R8: During reset, and in the first cycle after reset, out_valid is 0 and out_cause is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | Large-memory mode enable |
| rng_cfg | input | 16 | Valid window: end in [15:8], start in [7:0] |
| prot_addr | input | 34 | Protect address used on a fault |
| in_valid | input | 1 | Forward beat present |
| in_addr | input | 34 | Forward address, processor view |
| out_valid | output | 1 | Forward result present |
| out_addr | output | 34 | Adjusted or protect address |
| out_cause | output | 2 | 0 none, 1 I/O hole, 2 out of window |
| rev_in | input | 34 | Reverse-path address, device view |
| rev_out | output | 34 | Reverse-path address, processor view |

## Verification
Forward results, including the fault cause, are due on the clock edge that follows the beat. The bench drives each beat at a falling edge, predicts the result from its model, and compares it shortly after the next rising edge. This comparison is made on every clock, idle cycles included. The reverse path has no register, so its output is checked in the same half cycle as the stimulus, before the next rising edge.

// File: rtl/pawr_pkg.sv
package pawr_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_IOHOLE = 2'd1,
    CAUSE_RANGE = 2'd2
  } pawr_cause_e;
endpackage

// File: rtl/pawr_fwd_adj.sv
module pawr_fwd_adj #(
  parameter int PA_W      = 34,
  parameter int ALIAS_BIT = 32,
  parameter int HOLE_BITS = 30
) (
  input  logic            mode_en,
  input  logic [PA_W-1:0] addr_i,
  output logic [PA_W-1:0] addr_o,
  output logic            hole_o
);
  localparam logic [PA_W-1:0] ALIAS_MASK = PA_W'(1) << ALIAS_BIT;

  always_comb begin
    addr_o = mode_en ? (addr_i | ALIAS_MASK) : addr_i;
    hole_o = (addr_i[PA_W-1:HOLE_BITS] == '0);
  end
endmodule

// File: rtl/pawr_win_chk.sv
module pawr_win_chk #(
  parameter int PA_W    = 34,
  parameter int WIN_LSB = 30,
  parameter int WIN_MSB = 32,
  parameter int FLD_W   = 8
) (
  input  logic             check_en,
  input  logic [2*FLD_W-1:0] rng_cfg,
  input  logic [PA_W-1:0]  addr_i,
  output logic             outside_o
);
  localparam int WIN_W = WIN_MSB - WIN_LSB + 1;

  logic [FLD_W-1:0] lo_bound, hi_bound, win_val;

  always_comb begin
    lo_bound  = rng_cfg[FLD_W-1:0];
    hi_bound  = rng_cfg[2*FLD_W-1:FLD_W];
    win_val   = FLD_W'(addr_i[WIN_MSB:WIN_LSB]);
    outside_o = check_en && ((win_val < lo_bound) || (win_val > hi_bound));
  end

  if (WIN_W > FLD_W) begin : g_bad_width
    initial $error("window field wider than config field");
  end
endmodule

// File: rtl/pawr_rev_map.sv
module pawr_rev_map #(
  parameter int              PA_W      = 34,
  parameter int              ALIAS_BIT = 32,
  parameter logic [PA_W-1:0] REV_THR   = 34'h1_4000_0000
) (
  input  logic            mode_en,
  input  logic [PA_W-1:0] addr_i,
  output logic [PA_W-1:0] addr_o
);
  localparam logic [PA_W-1:0] CLR_MASK = ~(PA_W'(1) << ALIAS_BIT);

  always_comb begin
    if (mode_en && (addr_i >= REV_THR)) addr_o = addr_i & CLR_MASK;
    else                                addr_o = addr_i;
  end
endmodule

// File: rtl/pa_window_remap.sv
module pa_window_remap #(
  parameter int              PA_W      = 34,
  parameter int              ALIAS_BIT = 32,
  parameter int              WIN_LSB   = 30,
  parameter int              HOLE_BITS = 30,
  parameter int              FLD_W     = 8,
  parameter int              ALIGN_W   = 7,
  parameter logic [PA_W-1:0] REV_THR   = 34'h1_4000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_en,
  input  logic [2*FLD_W-1:0] rng_cfg,
  input  logic [PA_W-1:0]   prot_addr,
  input  logic              in_valid,
  input  logic [PA_W-1:0]   in_addr,
  output logic              out_valid,
  output logic [PA_W-1:0]   out_addr,
  output logic [1:0]        out_cause,
  input  logic [PA_W-1:0]   rev_in,
  output logic [PA_W-1:0]   rev_out
);
  import pawr_pkg::*;

  logic [PA_W-1:0] adj_addr, prot_aligned;
  logic            in_hole, out_win;
  pawr_cause_e     cause_d, cause_q;
  logic [PA_W-1:0] addr_d, addr_q;
  logic            valid_q;
  logic            addr_en;

  pawr_fwd_adj #(.PA_W(PA_W), .ALIAS_BIT(ALIAS_BIT), .HOLE_BITS(HOLE_BITS)) u_fwd (
    .mode_en(mode_en), .addr_i(in_addr), .addr_o(adj_addr), .hole_o(in_hole)
  );

  pawr_win_chk #(.PA_W(PA_W), .WIN_LSB(WIN_LSB), .WIN_MSB(ALIAS_BIT), .FLD_W(FLD_W)) u_win (
    .check_en(mode_en), .rng_cfg(rng_cfg), .addr_i(adj_addr), .outside_o(out_win)
  );

  pawr_rev_map #(.PA_W(PA_W), .ALIAS_BIT(ALIAS_BIT), .REV_THR(REV_THR)) u_rev (
    .mode_en(mode_en), .addr_i(rev_in), .addr_o(rev_out)
  );

  always_comb begin
    prot_aligned = {prot_addr[PA_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
    addr_en      = in_valid;
    cause_d      = CAUSE_NONE;
    addr_d       = adj_addr;
    if (in_valid) begin
      if (in_hole)      cause_d = CAUSE_IOHOLE;
      else if (out_win) cause_d = CAUSE_RANGE;
    end
    if (cause_d != CAUSE_NONE) addr_d = prot_aligned;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      valid_q <= in_valid;
      cause_q <= cause_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign out_valid = valid_q;
  assign out_addr  = addr_q;
  assign out_cause = cause_q;
endmodule

// File: rtl/pawr_checker.sv
module pawr_checker #(
  parameter int PA_W    = 34,
  parameter int ALIGN_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode_en,
  input logic            in_valid,
  input logic [PA_W-1:0] in_addr,
  input logic            out_valid,
  input logic [PA_W-1:0] out_addr,
  input logic [1:0]      out_cause,
  input logic [PA_W-1:0] rev_in,
  input logic [PA_W-1:0] rev_out
);
  AST_BIT32_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_en) |=> (out_cause != 2'd0 || out_addr[32])); // R1
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_REV_NO_BIT32: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && rev_in >= 34'h1_4000_0000) |-> !rev_out[32]); // R2
  AST_HOLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_addr[PA_W-1:30] == '0) |=> (out_cause == 2'd1)); // R3
  AST_PROT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cause != 2'd0) |-> (out_addr[ALIGN_W-1:0] == '0)); // R5
  AST_OFF_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode_en && in_addr[PA_W-1:30] != '0) |=>
      (out_cause == 2'd0 && out_addr == $past(in_addr))); // R6
  AST_REV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |-> (rev_out == rev_in)); // R6
  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cause != 2'd0) |-> out_valid); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && out_cause == 2'd0)); // R7
endmodule

bind pa_window_remap pawr_checker #(.PA_W(PA_W), .ALIGN_W(ALIGN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .in_valid(in_valid),
  .in_addr(in_addr), .out_valid(out_valid), .out_addr(out_addr),
  .out_cause(out_cause), .rev_in(rev_in), .rev_out(rev_out)
);

// File: tb/sim_pa_window_remap.sv
`timescale 1ns/100ps
module sim_pa_window_remap;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_en;
  logic [15:0] rng_cfg;
  logic [33:0] prot_addr, in_addr, rev_in;
  logic        in_valid;
  logic        out_valid;
  logic [33:0] out_addr, rev_out;
  logic [1:0]  out_cause;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic        exp_v;
  logic [33:0] exp_a;
  logic [1:0]  exp_c;

  always #2.5 clk = ~clk;

  pa_window_remap u0 (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .rng_cfg(rng_cfg),
    .prot_addr(prot_addr), .in_valid(in_valid), .in_addr(in_addr),
    .out_valid(out_valid), .out_addr(out_addr), .out_cause(out_cause),
    .rev_in(rev_in), .rev_out(rev_out)
  );

  function automatic logic [33:0] ref_rev(logic m, logic [33:0] a);
    if (m && a >= 34'h1_4000_0000) return a & ~(34'd1 << 32);
    return a;
  endfunction

  task automatic model(logic v, logic m, logic [15:0] rng, logic [33:0] p, logic [33:0] a);
    logic [33:0] adj;
    integer win;
    exp_v = v;
    exp_c = 2'd0;
    if (v) begin
      adj = m ? (a | (34'd1 << 32)) : a;
      win = adj[32:30];
      if (a < 34'h0_4000_0000) exp_c = 2'd1;
      else if (m && (win < rng[7:0] || win > rng[15:8])) exp_c = 2'd2;
      exp_a = (exp_c != 2'd0) ? {p[33:7], 7'd0} : adj;
    end
  endtask

  task automatic step(string req, logic v, logic [33:0] a, logic [33:0] r);
    logic [33:0] er;
    @(negedge clk);
    in_valid = v;
    in_addr  = a;
    rev_in   = r;
    model(v, mode_en, rng_cfg, prot_addr, a);
    #1;
    er = ref_rev(mode_en, r);
    checks++;
    if (rev_out !== er) begin
      failures++;
      $display("FAIL %s reverse: got %h expected %h", req, rev_out, er);
    end
    @(posedge clk);
    #1;
    checks++;
    if (out_valid !== exp_v || out_cause !== exp_c || (exp_v && out_addr !== exp_a)) begin
      failures++;
      $display("FAIL %s forward: got v=%b a=%h c=%0d expected v=%b a=%h c=%0d",
               req, out_valid, out_addr, out_cause, exp_v, exp_a, exp_c);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_en = 1'b1; rng_cfg = 16'h0704;
    prot_addr = 34'h2_ABCD_EF7F; in_valid = 1'b0; in_addr = '0; rev_in = '0;
    #12;
    checks++;
    if (out_valid !== 1'b0 || out_cause !== 2'd0) begin
      failures++;
      $display("FAIL R8 reset: got v=%b c=%0d expected v=0 c=0", out_valid, out_cause);
    end
    @(negedge clk); rst_n = 1'b1;
    step("R8", 0, 34'h0, 34'h0);
    // large-memory mode, full window 4..7
    step("R1", 1, 34'h0_8000_0000, 34'h1_4000_0000);
    step("R1", 1, 34'h1_2345_6780, 34'h1_3FFF_FFFF);
    step("R2", 1, 34'h0_FFFF_F000, 34'h1_FFFF_0000);
    step("R3", 1, 34'h0_0000_1000, 34'h0_1000_0000);
    step("R7", 0, 34'h0_0000_1000, 34'h3_4000_0000);
    // narrowed window start 5, end 6
    rng_cfg = 16'h0605;
    step("R4", 1, 34'h0_4000_0000, 34'h0);
    step("R4", 1, 34'h0_8000_0000, 34'h0);
    step("R4", 1, 34'h0_C000_0000, 34'h0);
    step("R4", 1, 34'h1_0000_0000, 34'h0);
    step("R5", 1, 34'h3_C000_0040, 34'h0);
    step("R3", 1, 34'h0_3FFF_FFFF, 34'h0);
    // mode off: identity, no window check
    mode_en = 1'b0;
    step("R6", 1, 34'h0_8000_0000, 34'h1_8000_0000);
    step("R6", 1, 34'h3_0000_0000, 34'h1_4000_0000);
    step("R3", 1, 34'h0_0000_0080, 34'h0);
    step("R7", 0, 34'h0, 34'h2_0000_0000);
    prot_addr = 34'h1_0000_00FF;
    mode_en = 1'b1; rng_cfg = 16'h0707;
    step("R4", 1, 34'h0_4000_0000, 34'h0);
    step("R4", 1, 34'h0_C000_0000, 34'h0);
    step("R7", 0, 34'h0, 34'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule